// File: doc/BRIEF.md
# Single-Precision Multiplier with Column-Sum Significand Core

This block multiplies two binary32 operands and returns a binary32 product with overflow and underflow flags. The significand product is not built from shifted partial-product rows. Each output column is formed directly as the count of all bit-products whose indices add up to that column's weight. A second step then ripples each column's carry into the next column up.

The datapath computes the sign and the biased exponent sum, and handles the implicit leading bit. It normalises by at most one place and truncates the fraction. NaN and infinity receive no special treatment. Subnormal operands and subnormal results are flushed to a signed zero. Exponent overflow saturates to the largest finite magnitude. A control module carries the valid token through two register stages and hands the datapath a pair of load strobes. A new operand pair can be accepted on every clock.

Top module: `fp32_xmul`

## Requirements
- R1: Operands and result use bit 31 as sign, bits 30:23 as exponent biased by 127 and bits 22:0 as stored fraction; the significand is the fraction with a leading 1 prepended, or a leading 0 when the exponent field is zero; a produced exponent field is never 255.
- R2: The result sign (bit 31) is the XOR of the two operand signs in every case, zero results included.
- R3: When either operand's exponent field is zero, the result is zero in bits 30:0 with the sign from R2, and both flags are low.
- R4: For nonzero operands whose 48-bit significand product has bit 47 clear, the result exponent is ea + eb - 127 and the fraction is product bits 45:23.
- R5: When the significand product has bit 47 set, the exponent is ea + eb - 126 and the fraction is product bits 46:24.
- R6: Product bits below the kept fraction are dropped (truncation toward zero in magnitude).
- R7: When the exponent from R4/R5 exceeds 254, ovfFlag is 1, unfFlag is 0 and bits 30:0 are exponent 254 with an all-ones fraction; an exponent of exactly 254 is not an overflow.
- R8: When the exponent from R4/R5 is below 1, unfFlag is 1, ovfFlag is 0 and bits 30:0 are zero; an exponent of exactly 1 is an ordinary result.
- R9: outValid is high exactly two clock edges after an edge that samples inValid high, and operand pairs sampled on consecutive edges each produce their own result.
- R10: After reset, outValid, result, ovfFlag and unfFlag are all zero.
- R11: While outValid is low, result, ovfFlag and unfFlag keep the values of the last valid output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair present this cycle |
| opA | input | 32 | First binary32 operand |
| opB | input | 32 | Second binary32 operand |
| outValid | output | 1 | Result present this cycle |
| result | output | 32 | binary32 product |
| ovfFlag | output | 1 | Exponent saturated high |
| unfFlag | output | 1 | Result flushed to zero by a low exponent |

## Verification
Every result, flag and valid bit is due on the second rising edge after the edge that samples the operands. There is no separate path with a shorter or longer delay. The bench drives a new pair at each falling edge and keeps a two-deep queue of expected outputs computed from the operands. At each falling edge, before driving the next pair, it compares the ports against the entry queued two steps earlier. An idle entry in that slot means the ports must instead show outValid low and the previous valid output unchanged.

// File: rtl/fp32_xmul_pkg.sv
package fp32_xmul_pkg;

  // Load strobes from the control module to the datapath
  typedef struct packed {
    logic ldIn;   // capture operands and column sums
    logic ldOut;  // capture the finished result
  } xmulStrobes_t;

endpackage

// File: rtl/xwise_sig_mul.sv
// Significand multiplier: per-column popcount of bit-products (registered),
// then a carry ripple from column to column.
module xwise_sig_mul #(
  parameter int SIG_W = 24
) (
  input  logic                 clk,
  input  logic                 ldCols,
  input  logic [SIG_W-1:0]     sigA,
  input  logic [SIG_W-1:0]     sigB,
  output logic [2*SIG_W-1:0]   prod
);
  localparam int NCOL = 2*SIG_W - 1;
  localparam int CW   = $clog2(SIG_W + 1);

  logic [CW-1:0] colSum [NCOL];
  logic [CW-1:0] colQ   [NCOL];
  logic [CW-1:0] carry  [NCOL+1];
  logic [CW:0]   colTot [NCOL];

  // Step one: every column k counts the products sigA[i] & sigB[k-i]
  for (genvar k = 0; k < NCOL; k++) begin : gCol
    localparam int LO = (k >= SIG_W) ? k - SIG_W + 1 : 0;
    localparam int HI = (k < SIG_W) ? k : SIG_W - 1;
    logic [HI-LO:0] bitProd;
    for (genvar i = LO; i <= HI; i++) begin : gBit
      assign bitProd[i-LO] = sigA[i] & sigB[k-i];
    end
    assign colSum[k] = CW'($countones(bitProd));
  end

  always_ff @(posedge clk) begin
    if (ldCols) colQ <= colSum;
  end

  // Step two: each column's carry moves one column up
  assign carry[0] = '0;
  for (genvar k = 0; k < NCOL; k++) begin : gRip
    assign colTot[k]  = {1'b0, colQ[k]} + {1'b0, carry[k]};
    assign prod[k]    = colTot[k][0];
    assign carry[k+1] = colTot[k][CW:1];
  end
  assign prod[2*SIG_W-1] = carry[NCOL][0];

  // The top carry is at most 1 since the product fits in 2*SIG_W bits
  logic unusedTopCarry;
  assign unusedTopCarry = ^carry[NCOL][CW-1:1];
endmodule

// File: rtl/fp32_xmul_ctrl.sv
module fp32_xmul_ctrl
  import fp32_xmul_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output xmulStrobes_t strobes,
  output logic         outValid
);
  logic midValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      midValid <= 1'b0;
      outValid <= 1'b0;
    end else begin
      midValid <= inValid;
      outValid <= midValid;
    end
  end

  always_comb begin
    strobes.ldIn  = inValid;
    strobes.ldOut = midValid;
  end
endmodule

// File: rtl/fp32_xmul_dpath.sv
module fp32_xmul_dpath
  import fp32_xmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  xmulStrobes_t                strobes,
  input  logic [EXP_W+FRAC_W:0]       opA,
  input  logic [EXP_W+FRAC_W:0]       opB,
  output logic [EXP_W+FRAC_W:0]       result,
  output logic                        ovfFlag,
  output logic                        unfFlag
);
  localparam int DATA_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PW     = 2 * SIG_W;
  localparam int XW     = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX   = (1 << EXP_W) - 2;

  // ---- stage one: unpack, exponent sum ----
  logic [EXP_W-1:0] expA, expB;
  logic             hidA, hidB;
  logic [SIG_W-1:0] sigA, sigB;

  assign expA = opA[DATA_W-2 -: EXP_W];
  assign expB = opB[DATA_W-2 -: EXP_W];
  assign hidA = |expA;
  assign hidB = |expB;
  assign sigA = {hidA, opA[FRAC_W-1:0]};
  assign sigB = {hidB, opB[FRAC_W-1:0]};

  logic          signQ;
  logic          zeroQ;
  logic [XW-1:0] expSumQ;

  always_ff @(posedge clk) begin
    if (strobes.ldIn) begin
      signQ   <= opA[DATA_W-1] ^ opB[DATA_W-1];
      zeroQ   <= ~(hidA & hidB);
      expSumQ <= XW'(expA) + XW'(expB) - XW'(BIAS);
    end
  end

  logic [PW-1:0] sigProd;

  xwise_sig_mul #(.SIG_W(SIG_W)) uCore (
    .clk    (clk),
    .ldCols (strobes.ldIn),
    .sigA   (sigA),
    .sigB   (sigB),
    .prod   (sigProd)
  );

  // ---- stage two: normalise, range check, pack ----
  logic              topBit;
  logic [FRAC_W-1:0] fracN;
  logic [XW-1:0]     expAdj;
  logic              isOvf, isUnf;
  logic [DATA_W-1:0] packed_d;

  assign topBit = sigProd[PW-1];
  assign fracN  = topBit ? sigProd[PW-2 -: FRAC_W] : sigProd[PW-3 -: FRAC_W];
  assign expAdj = expSumQ + XW'(topBit);
  assign isOvf  = !zeroQ && ($signed(expAdj) > $signed(XW'(EMAX)));
  assign isUnf  = !zeroQ && ($signed(expAdj) < $signed(XW'(1)));

  always_comb begin
    if (zeroQ || isUnf)
      packed_d = {signQ, {(DATA_W-1){1'b0}}};
    else if (isOvf)
      packed_d = {signQ, EXP_W'(EMAX), {FRAC_W{1'b1}}};
    else
      packed_d = {signQ, expAdj[EXP_W-1:0], fracN};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else if (strobes.ldOut) begin
      result  <= packed_d;
      ovfFlag <= isOvf;
      unfFlag <= isUnf;
    end
  end

  // Bits below the kept fraction are truncated away
  logic unusedLowBits;
  assign unusedLowBits = ^sigProd[SIG_W-2:0];
endmodule

// File: rtl/fp32_xmul.sv
module fp32_xmul
  import fp32_xmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  output logic                  outValid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  ovfFlag,
  output logic                  unfFlag
);
  xmulStrobes_t strobes;

  fp32_xmul_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  fp32_xmul_dpath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .ovfFlag (ovfFlag),
    .unfFlag (unfFlag)
  );
endmodule

// File: rtl/fp32_xmul_chk.sv
module fp32_xmul_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  inValid,
  input logic [EXP_W+FRAC_W:0] opA,
  input logic [EXP_W+FRAC_W:0] opB,
  input logic                  outValid,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  ovfFlag,
  input logic                  unfFlag
);
  localparam int DATA_W = 1 + EXP_W + FRAC_W;
  localparam int EMAX   = (1 << EXP_W) - 2;

  // Edges seen since reset, saturating at two
  logic [1:0] age;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2) |-> (outValid == $past(inValid, 2)));

  assert_sign_R2: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && outValid) |->
      (result[DATA_W-1] == ($past(opA[DATA_W-1], 2) ^ $past(opB[DATA_W-1], 2))));

  assert_zero_operand_R3: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd2 && outValid &&
     ($past(opA[DATA_W-2 -: EXP_W], 2) == '0 || $past(opB[DATA_W-2 -: EXP_W], 2) == '0)) |->
      (result[DATA_W-2:0] == '0 && !ovfFlag && !unfFlag));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(ovfFlag && unfFlag));

  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ovfFlag) |->
      (result[DATA_W-2 -: EXP_W] == EXP_W'(EMAX) && result[FRAC_W-1:0] == '1));

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && unfFlag) |-> (result[DATA_W-2:0] == '0));

  assert_no_top_exp_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (result[DATA_W-2 -: EXP_W] != '1));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(result) && $stable(ovfFlag) && $stable(unfFlag)));

  logic unusedFrac;
  assign unusedFrac = ^{opA[FRAC_W-1:0], opB[FRAC_W-1:0]};
endmodule

bind fp32_xmul fp32_xmul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opA      (opA),
  .opB      (opB),
  .outValid (outValid),
  .result   (result),
  .ovfFlag  (ovfFlag),
  .unfFlag  (unfFlag)
);

// File: tb/sim_fp32_xmul.sv
`timescale 1ns/1ps
module sim_fp32_xmul;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [31:0] opA, opB;
  logic        outValid;
  logic [31:0] result;
  logic        ovfFlag, unfFlag;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fp32_xmul u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  // Expected {ovf, unf, result} from the requirements
  function automatic logic [33:0] refMul(input logic [31:0] a, input logic [31:0] b);
    logic s;
    int ea, eb, e;
    logic [63:0] ma, mb, pr;
    logic [22:0] fr;
    s  = a[31] ^ b[31];                        // R2
    ea = a[30:23];
    eb = b[30:23];
    ma = {40'b0, 1'(ea != 0), a[22:0]};        // R1 implicit bit
    mb = {40'b0, 1'(eb != 0), b[22:0]};
    pr = ma * mb;
    if (ea == 0 || eb == 0) return {2'b00, s, 31'b0};        // R3
    e = ea + eb - 127;                                      // R4
    if (pr[47]) begin e = e + 1; fr = pr[46:24]; end        // R5
    else fr = pr[45:23];                                    // R6 truncation
    if (e > 254) return {2'b10, s, 8'd254, 23'h7FFFFF};     // R7
    if (e < 1)   return {2'b01, s, 31'b0};                  // R8
    return {2'b00, s, e[7:0], fr};
  endfunction

  logic        e1v = 1'b0, e2v = 1'b0;
  logic [33:0] e1 = '0, e2 = '0, lastOut = '0;
  string       e1tag = "", e2tag = "";

  task automatic checkOut();
    nChk++;
    if (e2v) begin
      if (outValid !== 1'b1 || {ovfFlag, unfFlag, result} !== e2) begin
        nFail++;
        $display("FAIL %s/R9: got v=%0b f=%b r=%h, expected v=1 f=%b r=%h",
                 e2tag, outValid, {ovfFlag, unfFlag}, result, e2[33:32], e2[31:0]);
      end
      lastOut = e2;
    end else begin
      if (outValid !== 1'b0 || {ovfFlag, unfFlag, result} !== lastOut) begin
        nFail++;
        $display("FAIL R11: got v=%0b f=%b r=%h, expected v=0 f=%b r=%h",
                 outValid, {ovfFlag, unfFlag}, result, lastOut[33:32], lastOut[31:0]);
      end
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b, input string tag);
    @(negedge clk);
    checkOut();
    e2v = e1v; e2 = e1; e2tag = e1tag;
    e1v = v;   e1 = refMul(a, b); e1tag = tag;
    inValid = v; opA = a; opB = b;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R9: watchdog expired, got no completion, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; inValid = 1'b0; opA = '0; opB = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    nChk++;  // R10 reset state
    if (outValid !== 1'b0 || result !== 32'h0 || ovfFlag !== 1'b0 || unfFlag !== 1'b0) begin
      nFail++;
      $display("FAIL R10: got v=%0b r=%h o=%0b u=%0b, expected all zero",
               outValid, result, ovfFlag, unfFlag);
    end

    // Directed corners, back to back
    step(1, 32'h3F800000, 32'h3F800000, "R1");   // 1.0 * 1.0
    step(1, 32'h00800000, 32'h3F800000, "R8");   // exponent exactly 1
    step(1, 32'hC0000000, 32'h40400000, "R2");   // -2 * 3
    step(1, 32'h00000000, 32'h40A00000, "R3");   // +0 * 5
    step(1, 32'h80000000, 32'h40A00000, "R3");   // -0 * 5
    step(1, 32'h00400000, 32'hBF800000, "R3");   // subnormal operand
    step(1, 32'h40400000, 32'h40A00000, "R4");   // 3 * 5, no shift
    step(1, 32'h3FC00000, 32'h3FC00000, "R5");   // 1.5 * 1.5, shift
    step(1, 32'h3F800001, 32'h3F800001, "R6");   // truncated tail
    step(1, 32'h3FFFFFFF, 32'h3FFFFFFF, "R6");
    step(1, 32'h7F000000, 32'h7F000000, "R7");   // overflow
    step(1, 32'hFF000000, 32'h43000000, "R7");   // negative overflow
    step(1, 32'h7F000000, 32'h3F800000, "R7");   // exponent exactly 254
    step(1, 32'h7F7FFFFF, 32'h3FFFFFFF, "R7");   // shift pushes past 254
    step(0, 32'h12345678, 32'h9ABCDEF0, "R11");  // idle: outputs hold
    step(0, 32'h0, 32'h0, "R11");
    step(1, 32'h00800000, 32'h00800000, "R8");   // underflow
    step(1, 32'h20000000, 32'h9F000000, "R8");   // negative underflow
    step(1, 32'h1FFFFFFF, 32'h1FFFFFFF, "R8");   // shift lands on exponent 0
    step(0, 32'h0, 32'h0, "R11");

    // Constrained random stream
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b;
      logic v;
      a = $urandom;
      b = $urandom;
      if ((n % 4) != 0) begin
        a[30:23] = 8'(64 + ($urandom % 128));
        b[30:23] = 8'(64 + ($urandom % 128));
      end
      v = (($urandom % 4) != 0);
      step(v, a, b, "R4");
    end

    step(0, 32'h0, 32'h0, "R11");
    step(0, 32'h0, 32'h0, "R11");
    step(0, 32'h0, 32'h0, "R11");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule